// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Fractional Mode

This block multiplies two 16-bit operands and adds the result into a running accumulator. The accumulator is 40 bits wide, which leaves eight guard bits above the 32-bit product. A two-bit mode input selects how the operands are read: as two's-complement integers, as unsigned integers, or as signed Q15 fractions. In Q15 mode the product is doubled so that the binary point stays aligned. The one product that cannot be represented, minus one times minus one, is clamped to the largest positive value, and the carry output is raised for it.

Each valid input beat takes one of two sources into the accumulator: the product of the operands, or a 32-bit addend supplied on the same beat. A clear control makes the beat load the accumulator from that source instead of adding to it. A width control keeps the full 40-bit sum, or folds the sum back to 32 bits by extending bit 31 into the upper byte. That extension copies the sign in the signed modes and fills with zeros in unsigned mode. The pipeline has two register stages: a multiply stage, then an accumulate stage. The result appears with its valid flag two clock edges after the input beat is sampled.

Top module: `mac_q15_unit`

## Requirements
- R1: After reset, `acc_out` is zero, and `out_valid` and `prod_carry` are low.
- R2: An input beat sampled with `in_valid` high at clock edge k produces `out_valid` high after edge k+2. A beat sampled with `in_valid` low produces `out_valid` low after edge k+2.
- R3: Mode encoding 0, and the reserved encoding 3, treat both operands as two's-complement integers. The product is their 32-bit signed product.
- R4: Mode encoding 1 treats both operands as unsigned integers. The 32-bit product is zero-extended into the accumulator.
- R5: Mode encoding 2 treats both operands as Q15 fractions. The product is the signed product shifted left by one bit.
- R6: In Q15 mode, 0x8000 times 0x8000 yields 0x7FFFFFFF, and `prod_carry` is 1 for that result. For every other beat `prod_carry` is 0.
- R7: A beat with `acc_clear` high loads the accumulator with its source value, and the previous total is discarded.
- R8: A beat with `acc_clear` low adds its source value to the stored total. When `wide_acc` is 1, the full 40-bit sum is kept, including carries above bit 31.
- R9: When `use_addend` is 1, `addend` replaces the product as the source. The addend is sign-extended in modes 0, 2 and 3, and zero-extended in mode 1.
- R10: When `wide_acc` is 0, bits 39:32 of the new total become copies of bit 31 in modes 0, 2 and 3, and zero in mode 1.
- R11: While `in_valid` is low, `acc_out` holds its value. Asserting `acc_clear`, `use_addend` or any data input during those cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat qualifier |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| mode | input | 2 | 0 signed, 1 unsigned, 2 Q15, 3 treated as signed |
| acc_clear | input | 1 | Load the accumulator instead of adding to it |
| use_addend | input | 1 | Take `addend` as the source instead of the product |
| addend | input | 32 | External value to accumulate |
| wide_acc | input | 1 | 1 keeps 40 bits, 0 folds the total to 32 bits |
| out_valid | output | 1 | Result qualifier, two edges after the input beat |
| acc_out | output | 40 | Accumulator total |
| prod_carry | output | 1 | Q15 saturation flag for the latest beat |

## Verification
The bench builds the block with its default widths: 16-bit operands, a 32-bit product and a 40-bit accumulator. With these widths, adding 0xFFFF squared twice carries into bit 32, which exercises the guard byte. A sum of three 0x7FFF squares crosses bit 31, so the wide and folded totals differ and both can be checked. The Q15 corner operand 0x8000 is also within reach. A stream of random beats mixes all modes, sources and widths back to back, which exercises the two-edge latency under full load.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        MODE_SINT = 2'd0,
        MODE_UINT = 2'd1,
        MODE_Q15  = 2'd2,
        MODE_RSVD = 2'd3
    } mac_mode_e;

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OP_W-1:0]      op_a,
    input  logic [OP_W-1:0]      op_b,
    input  mac_mode_e            mode,
    input  logic                 clear,
    input  logic                 use_addend,
    input  logic [2*OP_W-1:0]    addend,
    input  logic                 wide,
    output logic                 s1_valid,
    output logic [2*OP_W-1:0]    s1_prod,
    output logic                 s1_sat,
    output logic                 s1_clear,
    output logic                 s1_use_addend,
    output logic [2*OP_W-1:0]    s1_addend,
    output mac_mode_e            s1_mode,
    output logic                 s1_wide
);

    localparam int PROD_W = 2 * OP_W;
    localparam logic [OP_W-1:0]   OP_MIN   = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};

    logic signed [PROD_W-1:0] sprod;
    logic        [PROD_W-1:0] uprod;
    logic        [PROD_W-1:0] prod_d;
    logic                     sat_d;

    always_comb begin
        sprod = $signed({{OP_W{op_a[OP_W-1]}}, op_a}) * $signed({{OP_W{op_b[OP_W-1]}}, op_b});
        uprod = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
        sat_d = 1'b0;
        unique case (mode)
            MODE_UINT: prod_d = uprod;
            MODE_Q15: begin
                if (op_a == OP_MIN && op_b == OP_MIN) begin
                    prod_d = PROD_MAX;
                    sat_d  = 1'b1;
                end else begin
                    prod_d = {sprod[PROD_W-2:0], 1'b0};
                end
            end
            MODE_SINT, MODE_RSVD: prod_d = sprod;
            default: prod_d = sprod;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid      <= 1'b0;
            s1_prod       <= '0;
            s1_sat        <= 1'b0;
            s1_clear      <= 1'b0;
            s1_use_addend <= 1'b0;
            s1_addend     <= '0;
            s1_mode       <= MODE_SINT;
            s1_wide       <= 1'b1;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_prod       <= prod_d;
                s1_sat        <= sat_d;
                s1_clear      <= clear;
                s1_use_addend <= use_addend;
                s1_addend     <= addend;
                s1_mode       <= mode;
                s1_wide       <= wide;
            end
        end
    end

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import mac_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  logic [PROD_W-1:0]    s1_prod,
    input  logic                 s1_sat,
    input  logic                 s1_clear,
    input  logic                 s1_use_addend,
    input  logic [PROD_W-1:0]    s1_addend,
    input  mac_mode_e            s1_mode,
    input  logic                 s1_wide,
    output logic                 res_valid,
    output logic [ACC_W-1:0]     res_acc,
    output logic                 res_sat,
    output mac_mode_e            res_mode,
    output logic                 res_wide
);

    localparam int GUARD = ACC_W - PROD_W;

    logic [PROD_W-1:0] src;
    logic              src_signed;
    logic [ACC_W-1:0]  src_ext;
    logic [ACC_W-1:0]  sum;

    always_comb begin
        src        = s1_use_addend ? s1_addend : s1_prod;
        src_signed = (s1_mode != MODE_UINT);
        src_ext    = src_signed ? {{GUARD{src[PROD_W-1]}}, src} : {{GUARD{1'b0}}, src};
        sum        = s1_clear ? src_ext : (res_acc + src_ext);
        if (!s1_wide) begin
            sum[ACC_W-1:PROD_W] = src_signed ? {GUARD{sum[PROD_W-1]}} : {GUARD{1'b0}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_acc   <= '0;
            res_sat   <= 1'b0;
            res_mode  <= MODE_SINT;
            res_wide  <= 1'b1;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                res_acc  <= sum;
                res_sat  <= s1_sat;
                res_mode <= s1_mode;
                res_wide <= s1_wide;
            end
        end
    end

endmodule

// File: rtl/mac_q15_unit.sv
module mac_q15_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [OP_W-1:0]       op_a,
    input  logic [OP_W-1:0]       op_b,
    input  logic [1:0]            mode,
    input  logic                  acc_clear,
    input  logic                  use_addend,
    input  logic [2*OP_W-1:0]     addend,
    input  logic                  wide_acc,
    output logic                  out_valid,
    output logic [ACC_W-1:0]      acc_out,
    output logic                  prod_carry
);

    localparam int PROD_W = 2 * OP_W;

    logic              s1_valid;
    logic [PROD_W-1:0] s1_prod;
    logic              s1_sat;
    logic              s1_clear;
    logic              s1_use_addend;
    logic [PROD_W-1:0] s1_addend;
    mac_mode_e         s1_mode;
    logic              s1_wide;
    mac_mode_e         res_mode;
    logic              res_wide;

    mac_mul_stage #(.OP_W(OP_W)) u_mul (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .op_a          (op_a),
        .op_b          (op_b),
        .mode          (mac_mode_e'(mode)),
        .clear         (acc_clear),
        .use_addend    (use_addend),
        .addend        (addend),
        .wide          (wide_acc),
        .s1_valid      (s1_valid),
        .s1_prod       (s1_prod),
        .s1_sat        (s1_sat),
        .s1_clear      (s1_clear),
        .s1_use_addend (s1_use_addend),
        .s1_addend     (s1_addend),
        .s1_mode       (s1_mode),
        .s1_wide       (s1_wide)
    );

    mac_acc_stage #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk           (clk),
        .rst_n         (rst_n),
        .s1_valid      (s1_valid),
        .s1_prod       (s1_prod),
        .s1_sat        (s1_sat),
        .s1_clear      (s1_clear),
        .s1_use_addend (s1_use_addend),
        .s1_addend     (s1_addend),
        .s1_mode       (s1_mode),
        .s1_wide       (s1_wide),
        .res_valid     (out_valid),
        .res_acc       (acc_out),
        .res_sat       (prod_carry),
        .res_mode      (res_mode),
        .res_wide      (res_wide)
    );

endmodule

// File: rtl/mac_q15_unit_chk.sv
module mac_q15_unit_chk
    import mac_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [ACC_W-1:0] acc_out,
    input logic             prod_carry,
    input mac_mode_e        res_mode,
    input logic             res_wide
);

    localparam int GUARD = ACC_W - PROD_W;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2

    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R2

    AST_CARRY_ONLY_Q15: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && prod_carry) |-> (res_mode == MODE_Q15)); // R6

    AST_NARROW_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_wide && res_mode != MODE_UINT)
            |-> (acc_out[ACC_W-1:PROD_W] == {GUARD{acc_out[PROD_W-1]}})); // R10

    AST_NARROW_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_wide && res_mode == MODE_UINT)
            |-> (acc_out[ACC_W-1:PROD_W] == '0)); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(acc_out)); // R11

endmodule

bind mac_q15_unit mac_q15_unit_chk #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .acc_out    (acc_out),
    .prod_carry (prod_carry),
    .res_mode   (res_mode),
    .res_wide   (res_wide)
);

// File: tb/tb_mac_q15_unit.sv
module tb_mac_q15_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] op_a, op_b;
    logic [1:0]  mode;
    logic        acc_clear, use_addend, wide_acc;
    logic [31:0] addend;
    logic        out_valid;
    logic [39:0] acc_out;
    logic        prod_carry;

    mac_q15_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .acc_clear(acc_clear), .use_addend(use_addend), .addend(addend),
        .wide_acc(wide_acc), .out_valid(out_valid), .acc_out(acc_out), .prod_carry(prod_carry)
    );

    always #10 clk = ~clk;

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    logic [39:0] m_acc = '0;
    logic [39:0] last_acc = '0;
    logic [39:0] q_acc[$];
    logic        q_car[$];
    string       q_tag[$];
    longint      q_cyc[$];
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic send(input logic [15:0] a, input logic [15:0] b, input logic [1:0] md,
                        input logic clr, input logic ua, input logic [31:0] ad,
                        input logic w, input string tag);
        logic signed [31:0] sp;
        logic [31:0] p, s;
        logic        sat, sgn;
        logic [39:0] src;
        sat = 1'b0;
        sgn = (md != 2'd1);
        sp  = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
        case (md)
            2'd1: p = {16'h0, a} * {16'h0, b};
            2'd2: begin
                if (a == 16'h8000 && b == 16'h8000) begin
                    p = 32'h7FFF_FFFF; sat = 1'b1;
                end else begin
                    p = sp << 1;
                end
            end
            default: p = sp;
        endcase
        s   = ua ? ad : p;
        src = sgn ? {{8{s[31]}}, s} : {8'h00, s};
        m_acc = clr ? src : (m_acc + src);
        if (!w) m_acc[39:32] = sgn ? {8{m_acc[31]}} : 8'h00;
        q_acc.push_back(m_acc);
        q_car.push_back(sat);
        q_tag.push_back(tag);
        q_cyc.push_back(cyc);
        op_a = a; op_b = b; mode = md; acc_clear = clr; use_addend = ua;
        addend = ad; wide_acc = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the expected item for each result beat.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid) begin
                if (q_acc.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
                end else begin
                    logic [39:0] ea; logic ec; string et; longint ecy;
                    ea = q_acc.pop_front(); ec = q_car.pop_front();
                    et = q_tag.pop_front(); ecy = q_cyc.pop_front();
                    checks++;
                    if (acc_out !== ea) begin
                        fails++;
                        $display("FAIL %s acc_out: actual %h expected %h", et, acc_out, ea);
                    end
                    checks++;
                    if (prod_carry !== ec) begin
                        fails++;
                        $display("FAIL R6 prod_carry (%s): actual %b expected %b", et, prod_carry, ec);
                    end
                    checks++;
                    if (cyc != ecy + 2) begin
                        fails++;
                        $display("FAIL R2 latency (%s): actual %0d expected %0d", et, cyc - ecy, 2);
                    end
                end
            end else begin
                checks++;
                if (acc_out !== last_acc) begin
                    fails++;
                    $display("FAIL R11 hold: actual %h expected %h", acc_out, last_acc);
                end
            end
            last_acc = acc_out;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual pending=%0d expected 0", q_acc.size());
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; mode = '0;
        acc_clear = 1'b0; use_addend = 1'b0; addend = '0; wide_acc = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (acc_out !== 40'h0 || out_valid !== 1'b0 || prod_carry !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual %h/%b/%b expected 0/0/0", acc_out, out_valid, prod_carry);
        end

        send(16'd3, 16'hFFFB, 2'd0, 1, 0, 0, 1, "R3_R7 signed load");
        send(16'd100, 16'd200, 2'd0, 0, 0, 0, 1, "R8 signed add");
        send(16'hFFFF, 16'hFFFF, 2'd1, 1, 0, 0, 1, "R4 unsigned load");
        send(16'hFFFF, 16'hFFFF, 2'd1, 0, 0, 0, 1, "R8 guard carry");
        send(16'h4000, 16'h4000, 2'd2, 1, 0, 0, 1, "R5 q15 half squared");
        send(16'hC000, 16'h4000, 2'd2, 0, 0, 0, 1, "R5 q15 negative add");
        send(16'h8000, 16'h8000, 2'd2, 1, 0, 0, 1, "R6 q15 saturate");
        send(16'h8000, 16'h7FFF, 2'd2, 1, 0, 0, 1, "R6 q15 no saturate");
        send(16'h0, 16'h0, 2'd0, 1, 1, 32'h8000_0000, 1, "R9 signed addend");
        send(16'h0, 16'h0, 2'd1, 1, 1, 32'h8000_0000, 1, "R9 unsigned addend");
        send(16'hFFFF, 16'h2, 2'd3, 1, 0, 0, 1, "R3 reserved mode");
        send(16'h7FFF, 16'h7FFF, 2'd0, 1, 0, 0, 0, "R10 narrow load");
        send(16'h7FFF, 16'h7FFF, 2'd0, 0, 0, 0, 0, "R10 narrow add");
        send(16'h7FFF, 16'h7FFF, 2'd0, 0, 0, 0, 0, "R10 narrow sign fold");
        send(16'h7FFF, 16'h7FFF, 2'd0, 1, 0, 0, 1, "R8 wide load");
        send(16'h7FFF, 16'h7FFF, 2'd0, 0, 0, 0, 1, "R8 wide add");
        send(16'h7FFF, 16'h7FFF, 2'd0, 0, 0, 0, 1, "R8 wide past bit31");
        send(16'h0, 16'h0, 2'd1, 1, 1, 32'hFFFF_FFFF, 0, "R10 unsigned narrow load");
        send(16'h0, 16'h0, 2'd1, 0, 1, 32'h1, 0, "R10 unsigned narrow wrap");

        // Idle cycles with controls toggling: nothing may change (R11).
        op_a = 16'h1234; op_b = 16'h5678; acc_clear = 1'b1; use_addend = 1'b1;
        addend = 32'hDEAD_BEEF; wide_acc = 1'b0;
        repeat (4) @(negedge clk);
        send(16'd5, 16'd7, 2'd0, 0, 0, 0, 1, "R11 add after idle");

        for (int i = 0; i < 60; i++) begin
            send(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom % 5 == 0),
                 1'($urandom % 4 == 0), $urandom, 1'($urandom % 3 != 0), "R2 random stream");
            if (i % 7 == 6) @(negedge clk);
        end

        repeat (5) @(negedge clk);
        checks++;
        if (q_acc.size() != 0) begin
            fails++;
            $display("FAIL R2 drain: actual pending=%0d expected 0", q_acc.size());
        end
        done = 1;
        finish_run();
    end

endmodule